// File: doc/BRIEF.md
# GPIO External Interrupt Controller

This unit watches 32 general-purpose input lines and turns activity on them into interrupt events. Each line first passes through a two-flop synchronizer. A detector then compares the line against the trigger mode chosen for that line: rising edge, falling edge, either edge, high level or low level. When a line's condition is met, its pending bit is latched, whether or not the line is enabled.

Software sees the unit through a small register port. It programs a 4-bit trigger field per line and a per-line enable mask. It reads the pending bits and clears them by writing ones. The unit drives a single registered interrupt output. That output is high while any pending line is also enabled.

The register port is a request channel with `bus_valid` and `bus_ready`. `bus_ready` is tied high, so a request is accepted in every cycle in which `bus_valid` is high, and there is never back-pressure. An accepted read returns its data on `rsp_rdata`, with `rsp_valid` high for exactly one cycle, on the cycle after acceptance. The response has no ready signal, so the requester must take the data in that cycle. Writes produce no response.

Top module: `gpio_eint_ctrl`

## Requirements
- R1: After reset, every trigger field, the enable mask and the pending mask read as zero, and `irq_o` is low.
- R2: The trigger field of line n is 4 bits wide. It sits at bit 4*(n mod 8) of the configuration word at offset 0x200 + 4*(n/8). The four words at 0x200, 0x204, 0x208 and 0x20C read back what was written.
- R3: Trigger code 0 latches the pending bit when a rising edge is seen on the synchronized line. It does not latch on a falling edge.
- R4: Trigger code 1 latches the pending bit on a falling edge. It does not latch on a rising edge.
- R5: Trigger code 2 latches the pending bit while the synchronized line is high. Trigger code 3 latches it while the line is low. Neither code latches while its level is absent.
- R6: Trigger code 4 latches the pending bit on either edge.
- R7: Trigger codes 5 to 15 never latch a pending bit.
- R8: A pending bit sets regardless of the enable bit for its line. It holds until software writes 1 to that bit of the pending register at offset 0x214, where line n is bit n. Writing 0 to a bit leaves it unchanged.
- R9: A clear of a level-mode line takes effect for one cycle, and the bit sets again on the next cycle while the level persists. An edge that is detected in the same cycle as a clear of its line keeps the pending bit set.
- R10: `irq_o` is a register. In each cycle it equals the OR over all lines of (pending AND enable) from the previous cycle. The enable mask is at offset 0x210, with line n at bit n.
- R11: A read of any offset other than the six mapped words returns zero.
- R12: `bus_ready` is always high. `rsp_valid` is high exactly in the cycle after an accepted read, and never follows a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | LINES | Raw, unsynchronized input lines |
| bus_valid | input | 1 | Register request present |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | DATA_W | Read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 32 lines, 32-bit data, a 12-bit offset and a two-stage synchronizer. Every configuration word and every bit of the masks are therefore live. This setting covers lines at both ends of the range (lines 0 and 31) and lines in each of the four configuration words. It also makes the three-edge path from a pin change to a pending bit deterministic, which lets the bench land a clear on the exact cycle an edge is detected. It also lets the bench watch the one-cycle dip of the interrupt output when a level-mode line is cleared.

// File: rtl/eint_pkg.sv
package eint_pkg;

  typedef enum logic [3:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;

  localparam int unsigned OFS_CFG    = 32'h200;
  localparam int unsigned OFS_ENABLE = 32'h210;
  localparam int unsigned OFS_STATUS = 32'h214;
  localparam int unsigned FIELD_W    = 4;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         level,
  input  logic [FIELD_W*LINES-1:0] trig,
  output logic [LINES-1:0]         edge_hit,
  output logic [LINES-1:0]         level_hit
);

  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [FIELD_W-1:0] code;
    logic rise, fall;
    assign code = trig[FIELD_W*n +: FIELD_W];
    assign rise = level[n] & ~prev_q[n];
    assign fall = ~level[n] & prev_q[n];

    always_comb begin
      edge_hit[n]  = 1'b0;
      level_hit[n] = 1'b0;
      case (code)
        TRIG_RISE: edge_hit[n]  = rise;
        TRIG_FALL: edge_hit[n]  = fall;
        TRIG_BOTH: edge_hit[n]  = rise | fall;
        TRIG_HIGH: level_hit[n] = level[n];
        TRIG_LOW:  level_hit[n] = ~level[n];
        default: begin
          edge_hit[n]  = 1'b0;
          level_hit[n] = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [LINES-1:0]         edge_hit,
  input  logic [LINES-1:0]         level_hit,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [FIELD_W*LINES-1:0] trig,
  output logic [LINES-1:0]         enable_q,
  output logic [LINES-1:0]         status_q
);

  localparam int PER_WORD  = DATA_W / FIELD_W;
  localparam int CFG_WORDS = LINES / PER_WORD;

  logic [CFG_WORDS-1:0][DATA_W-1:0] cfg_q;
  logic                             wr, rd;
  logic [LINES-1:0]                 clr;
  logic [DATA_W-1:0]                rd_word;

  assign wr   = bus_valid & bus_write;
  assign rd   = bus_valid & ~bus_write;
  assign trig = cfg_q;
  assign clr  = (wr && bus_addr == ADDR_W'(OFS_STATUS)) ? bus_wdata[LINES-1:0] : '0;

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[w] <= '0;
      else if (wr && bus_addr == ADDR_W'(OFS_CFG + 4 * w)) cfg_q[w] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      status_q <= '0;
    end else begin
      if (wr && bus_addr == ADDR_W'(OFS_ENABLE)) enable_q <= bus_wdata[LINES-1:0];
      // edges outrank a clear; levels lose to it for one cycle
      status_q <= (status_q & ~clr) | edge_hit | (level_hit & ~clr);
    end
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_W'(OFS_ENABLE)) rd_word = DATA_W'(enable_q);
    if (bus_addr == ADDR_W'(OFS_STATUS)) rd_word = DATA_W'(status_q);
    for (int w = 0; w < CFG_WORDS; w++) begin
      if (bus_addr == ADDR_W'(OFS_CFG + 4 * w)) rd_word = cfg_q[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/gpio_eint_ctrl.sv
module gpio_eint_ctrl
  import eint_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  pin_i,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_o
);

  logic [LINES-1:0]         pin_sync;
  logic [LINES-1:0]         edge_hit, level_hit;
  logic [FIELD_W*LINES-1:0] trig;
  logic [LINES-1:0]         enable_q, status_q;

  assign bus_ready = 1'b1;

  eint_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_sync)
  );

  eint_detect #(.LINES(LINES)) u_detect (
    .clk(clk), .rst_n(rst_n), .level(pin_sync), .trig(trig),
    .edge_hit(edge_hit), .level_hit(level_hit)
  );

  eint_regs #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .edge_hit(edge_hit), .level_hit(level_hit),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .trig(trig), .enable_q(enable_q), .status_q(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(status_q & enable_q);
  end

endmodule

// File: rtl/eint_checker.sv
module eint_checker
  import eint_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_valid,
  input logic                     bus_ready,
  input logic                     bus_write,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic                     rsp_valid,
  input logic                     irq_o,
  input logic [FIELD_W*LINES-1:0] trig,
  input logic [LINES-1:0]         enable_q,
  input logic [LINES-1:0]         status_q
);

  logic [LINES-1:0] clear_req;
  assign clear_req = (bus_valid && bus_write && bus_addr == ADDR_W'(OFS_STATUS))
                     ? bus_wdata[LINES-1:0] : '0;

  assert_ready_R12: assert property (@(posedge clk) disable iff (!rst_n) bus_ready);

  assert_rsp_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(bus_valid && !bus_write));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(status_q & enable_q)));

  for (genvar n = 0; n < LINES; n++) begin : g_line
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_q[n]) |-> $past(clear_req[n]));

    assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[n]) |-> ($past(trig[FIELD_W*n +: FIELD_W]) <= 4'd4));
  end

endmodule

bind gpio_eint_ctrl eint_checker #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .rsp_valid(rsp_valid), .irq_o(irq_o), .trig(trig),
  .enable_q(enable_q), .status_q(status_q)
);

// File: tb/tb_gpio_eint_ctrl.sv
module tb_gpio_eint_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CFG = 12'h200;
  localparam logic [11:0] A_EN  = 12'h210;
  localparam logic [11:0] A_ST  = 12'h214;

  typedef struct packed {
    logic [4:0] line;
    logic [3:0] mode;
    logic       s;
    logic       f;
    logic       en;
    logic       exp;
  } vec_t;

  // line, mode, start level, end level, enable, expected pending
  localparam vec_t VECS [14] = '{
    '{5'd0,  4'd0,  1'b0, 1'b1, 1'b1, 1'b1},
    '{5'd9,  4'd0,  1'b1, 1'b0, 1'b1, 1'b0},
    '{5'd17, 4'd1,  1'b1, 1'b0, 1'b1, 1'b1},
    '{5'd5,  4'd1,  1'b0, 1'b1, 1'b1, 1'b0},
    '{5'd31, 4'd2,  1'b0, 1'b1, 1'b1, 1'b1},
    '{5'd12, 4'd2,  1'b0, 1'b0, 1'b1, 1'b0},
    '{5'd24, 4'd3,  1'b1, 1'b0, 1'b0, 1'b1},
    '{5'd7,  4'd3,  1'b1, 1'b1, 1'b1, 1'b0},
    '{5'd20, 4'd4,  1'b0, 1'b1, 1'b1, 1'b1},
    '{5'd27, 4'd4,  1'b1, 1'b0, 1'b1, 1'b1},
    '{5'd3,  4'd6,  1'b0, 1'b1, 1'b1, 1'b0},
    '{5'd14, 4'd15, 1'b1, 1'b0, 1'b1, 1'b0},
    '{5'd16, 4'd5,  1'b0, 1'b1, 1'b1, 1'b0},
    '{5'd30, 4'd2,  1'b1, 1'b1, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rsp_valid, irq_o;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  logic [127:0] cfg_sh;
  logic [31:0]  rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_eint_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    chk("R12 no response to write", {31'd0, rsp_valid}, 32'd0);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R12 read response valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic set_mode(input int line, input logic [3:0] m);
    cfg_sh[4*line +: 4] = m;
    bus_wr(A_CFG + 12'(4 * (line / 8)), cfg_sh[32*(line/8) +: 32]);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    for (int w = 0; w < 4; w++) begin
      bus_rd(A_CFG + 12'(4 * w), rd);
      chk("R1 cfg word reset", rd, 32'd0);
    end
    bus_rd(A_EN, rd); chk("R1 enable reset", rd, 32'd0);
    bus_rd(A_ST, rd); chk("R1 status reset", rd, 32'd0);

    // R2 field layout and readback
    for (int w = 0; w < 4; w++) bus_wr(A_CFG + 12'(4 * w), 32'hFEDC_BA90 + 32'(w));
    for (int w = 0; w < 4; w++) begin
      bus_rd(A_CFG + 12'(4 * w), rd);
      chk("R2 cfg word readback", rd, 32'hFEDC_BA90 + 32'(w));
    end
    bus_wr(A_EN, 32'hA5A5_0F0F);
    bus_rd(A_EN, rd); chk("R10 enable readback", rd, 32'hA5A5_0F0F);
    bus_wr(A_EN, 32'd0);

    // R11 unmapped offsets
    bus_rd(12'h218, rd); chk("R11 unmapped 0x218", rd, 32'd0);
    bus_rd(12'h000, rd); chk("R11 unmapped 0x000", rd, 32'd0);
    bus_rd(12'h1FC, rd); chk("R11 unmapped 0x1FC", rd, 32'd0);

    // park every line in a reserved code, then clear pending
    cfg_sh = {32{4'd5}};
    for (int w = 0; w < 4; w++) bus_wr(A_CFG + 12'(4 * w), cfg_sh[32*w +: 32]);
    bus_wr(A_ST, 32'hFFFF_FFFF);
    idle(2);
    bus_rd(A_ST, rd); chk("R7 parked lines quiet", rd, 32'd0);

    // vector table: R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < 14; i++) begin
      @(negedge clk); pins[VECS[i].line] = VECS[i].s;
      idle(4);
      bus_wr(A_ST, 32'd1 << VECS[i].line);
      bus_wr(A_EN, {31'd0, VECS[i].en} << VECS[i].line);
      set_mode(int'(VECS[i].line), VECS[i].mode);
      @(negedge clk); pins[VECS[i].line] = VECS[i].f;
      idle(6);
      bus_rd(A_ST, rd);
      chk($sformatf("R3/R4/R5/R6/R7 vector %0d mode %0d pending", i, VECS[i].mode),
          rd, {31'd0, VECS[i].exp} << VECS[i].line);
      chk($sformatf("R10 vector %0d irq", i), {31'd0, irq_o},
          {31'd0, VECS[i].exp & VECS[i].en});
      set_mode(int'(VECS[i].line), 4'd5);
      bus_wr(A_EN, 32'd0);
      bus_wr(A_ST, 32'd1 << VECS[i].line);
    end

    // R8 sticky, write-0 ignored, write-1 clears; R10 enable gating
    pins[1] = 1'b0;
    set_mode(1, 4'd0);
    @(negedge clk); pins[1] = 1'b1;
    idle(5);
    pins[1] = 1'b0;
    idle(5);
    bus_rd(A_ST, rd); chk("R8 pending held after pulse", rd, 32'h2);
    chk("R8 disabled line gives no irq", {31'd0, irq_o}, 32'd0);
    bus_wr(A_ST, 32'hFFFF_FFFD);
    bus_rd(A_ST, rd); chk("R8 writing 0 keeps bit", rd, 32'h2);
    bus_wr(A_EN, 32'h2);
    idle(1);
    chk("R10 irq after enable", {31'd0, irq_o}, 32'd1);
    bus_wr(A_ST, 32'h2);
    idle(1);
    bus_rd(A_ST, rd); chk("R8 write 1 clears", rd, 32'd0);
    chk("R10 irq drops after clear", {31'd0, irq_o}, 32'd0);
    set_mode(1, 4'd5);
    bus_wr(A_EN, 32'd0);

    // R9 edge detected in the same cycle as a clear keeps pending set
    set_mode(2, 4'd4);
    @(negedge clk); pins[2] = 1'b1;
    @(negedge clk);
    bus_wr(A_ST, 32'h4);
    idle(2);
    bus_rd(A_ST, rd); chk("R9 edge beats coincident clear", rd, 32'h4);
    bus_wr(A_ST, 32'h4);
    idle(2);
    bus_rd(A_ST, rd); chk("R9 edge line clears when idle", rd, 32'd0);

    // R9 level line re-asserts one cycle after a clear
    set_mode(2, 4'd2);
    bus_wr(A_EN, 32'h4);
    idle(3);
    chk("R9 level irq high", {31'd0, irq_o}, 32'd1);
    bus_wr(A_ST, 32'h4);
    @(negedge clk);
    chk("R9 irq dips one cycle", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R9 irq back after dip", {31'd0, irq_o}, 32'd1);
    bus_rd(A_ST, rd); chk("R9 level re-set pending", rd, 32'h4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule